// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block lets on-chip logic use a small three-wire serial EEPROM of 64 sixteen-bit words. The host places a command code, a word address and, when needed, a write word on a parallel command port, then pulses a start strobe. The controller raises chip select and builds the serial frame. It derives the serial clock from the system clock, shifts the frame out, and shifts read data in. After a program or erase it waits out the device's internal write cycle by polling the device's ready indication.

The full command set is supported: single-word read, write and erase, whole-array erase and write, and the enable and disable of programming. The device ignores program and erase frames until programming has been enabled. The controller forwards every command it is given and leaves that gating to the device. A program command ends either when the device reports ready or when a programmable poll limit runs out. In the second case the command is reported with an error flag.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset, chip select, serial clock, serial data out, busy and done are all low.
- R2: Each frame starts with chip select high and a 1 bit, followed by a 2-bit device opcode and the 6-bit address, sent MSB first. The device opcodes are read=10, write=01, erase=11 and 00 for the special commands. A special command puts its selector in the top two address bits (enable=11, erase-all=10, write-all=01, disable=00) and zeros in the rest. The host command codes are 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 enable, 6 disable.
- R3: The serial clock is high and low for HALF_DIV system clocks each while it runs. Serial data out changes only while the serial clock is low, so it is stable across every rising edge.
- R4: A read skips one dummy bit after the address. It then samples 16 bits, MSB first, on rising serial clock edges and presents them on rdata_o when done is asserted. An erased word reads 0xFFFF.
- R5: Write and write-all send the 16-bit write word, MSB first, directly after the address bits.
- R6: After write, erase, erase-all or write-all, chip select goes low for at least one full serial clock period and then high again. The controller samples data in on each rising edge and asserts done only after it has seen a 1 (ready).
- R7: If ready is not seen within TIMEOUT_PERIODS serial clock periods of polling, the command ends with done and err_o high.
- R8: Enable and disable send only the 9-bit frame. They raise chip select once, do no polling, and end with err_o low.
- R9: A start strobe while busy_o is high has no effect. A start strobe with command code 7 starts nothing.
- R10: done_o is a single-cycle pulse, given with busy_o low. err_o is low for every command that ends normally.
- R11: Chip select changes only while the serial clock is low, and the serial clock is held low while the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Command strobe, taken only when idle |
| cmd_i | input | 3 | Host command code |
| addr_i | input | 6 | Word address |
| wdata_i | input | 16 | Word to program for write and write-all |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| err_o | output | 1 | Ready poll timed out (valid with done) |
| rdata_o | output | 16 | Last word read |
| cs_o | output | 1 | Device chip select |
| sk_o | output | 1 | Device serial clock |
| di_o | output | 1 | Serial data to the device |
| do_i | input | 1 | Serial data and ready status from the device |

## Verification
The assertions check the per-cycle rules on every clock: chip select is low when idle, data is stable while the serial clock is high, chip select moves only with the clock low, done lasts one cycle, the latched command is held during a transfer, and the poll counter stays in range. Other behaviour can only be shown by the bench's scenarios, which run against a behavioural device model. These are the bit content of each frame, the dummy-bit skip on reads, the device's enable gating as seen through read-back, the cs-low gap and re-selection before polling, the wait for ready, and the timeout path.

// File: rtl/mw_pkg.sv
// Shared types for the serial EEPROM command master.
// Assumes: host command codes are fixed at 3 bits; code 7 is reserved.
package mw_pkg;
    typedef enum logic [2:0] {
        HC_READ      = 3'd0,
        HC_WRITE     = 3'd1,
        HC_ERASE     = 3'd2,
        HC_ERASE_ALL = 3'd3,
        HC_WRITE_ALL = 3'd4,
        HC_WR_EN     = 3'd5,
        HC_WR_DIS    = 3'd6,
        HC_RSVD      = 3'd7
    } host_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_RECV,
        ST_GAP,
        ST_POLL,
        ST_END
    } ctl_state_e;

    localparam logic [1:0] OP_SPECIAL = 2'b00;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_ERASE   = 2'b11;

    localparam logic [1:0] SEL_DIS    = 2'b00;
    localparam logic [1:0] SEL_WRALL  = 2'b01;
    localparam logic [1:0] SEL_ERALL  = 2'b10;
    localparam logic [1:0] SEL_EN     = 2'b11;
endpackage

// File: rtl/mw_frame_fmt.sv
// Frame formatter: maps a host command and address onto the 9-bit device
// header (start bit, opcode, address) and classifies the command.
// Assumes: ADDR_W >= 2, since special commands use the top two address bits.
module mw_frame_fmt
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [2:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W+2:0] hdr_o,
    output logic              with_data_o,
    output logic              is_read_o,
    output logic              is_prog_o,
    output logic              legal_o
);
    localparam int LOW_W = ADDR_W - 2;

    logic [1:0]        op;
    logic [ADDR_W-1:0] field;

    // Decode the host code into opcode, address field and class flags.
    always_comb begin
        op          = OP_SPECIAL;
        field       = addr_i;
        with_data_o = 1'b0;
        is_read_o   = 1'b0;
        is_prog_o   = 1'b0;
        legal_o     = 1'b1;
        case (host_cmd_e'(cmd_i))
            HC_READ:      begin op = OP_READ;  is_read_o = 1'b1; end
            HC_WRITE:     begin op = OP_WRITE; with_data_o = 1'b1; is_prog_o = 1'b1; end
            HC_ERASE:     begin op = OP_ERASE; is_prog_o = 1'b1; end
            HC_ERASE_ALL: begin field = {SEL_ERALL, {LOW_W{1'b0}}}; is_prog_o = 1'b1; end
            HC_WRITE_ALL: begin field = {SEL_WRALL, {LOW_W{1'b0}}}; with_data_o = 1'b1; is_prog_o = 1'b1; end
            HC_WR_EN:     field = {SEL_EN,  {LOW_W{1'b0}}};
            HC_WR_DIS:    field = {SEL_DIS, {LOW_W{1'b0}}};
            default:      legal_o = 1'b0;
        endcase
        hdr_o = {1'b1, op, field};
    end
endmodule

// File: rtl/mw_sclk_gen.sv
// Serial clock generator: while run_i is high, toggles sk every HALF_DIV
// system clocks and flags the edge where sk rises or falls.
// Assumes: HALF_DIV >= 2; sk parks low whenever run_i is low.
module mw_sclk_gen #(
    parameter int HALF_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick   = run_i && (cnt == LAST);
    assign rise_o = tick && !sk_o;
    assign fall_o = tick && sk_o;

    // Count half periods and toggle the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt  <= '0;
            sk_o <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sk_o <= !sk_o;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R11
    sk_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sk_o);
endmodule

// File: rtl/mw_poll_timer.sv
// Poll timer: counts serial periods spent waiting for ready and flags
// when LIMIT periods have passed.
// Assumes: clr_i is held in the cycles before polling starts.
module mw_poll_timer #(
    parameter int LIMIT = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic expired_o
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] TOP = TW'(LIMIT);

    logic [TW-1:0] cnt;

    assign expired_o = (cnt >= TOP);

    // Saturating period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cnt <= '0;
        else if (inc_i && !expired_o)
            cnt <= cnt + 1'b1;
    end

    // R7
    tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);
endmodule

// File: rtl/mw_eeprom_ctrl.sv
// Command master for a three-wire serial EEPROM of 2**ADDR_W words.
// Builds the frame, shifts it out on falling serial clock edges, samples
// read data and ready status on rising edges, and polls for the end of
// program cycles with a timeout.
// Assumes: the device samples data on rising edges and drives its output
// after them; the host holds its command inputs stable during start_i.
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int ADDR_W          = 6,
    parameter int DATA_W          = 16,
    parameter int HALF_DIV        = 32,
    parameter int TIMEOUT_PERIODS = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    input  logic              do_i
);
    localparam int HDR_W = ADDR_W + 3;
    localparam int SH_W  = HDR_W + DATA_W;
    localparam int CNT_W = $clog2(SH_W + 1);
    localparam logic [CNT_W-1:0] HDR_BITS  = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] FULL_BITS = CNT_W'(SH_W);
    localparam logic [CNT_W-1:0] RD_BITS   = CNT_W'(DATA_W + 1);

    ctl_state_e        state;
    logic [2:0]        cmd_q;
    logic              wr_q, rd_q, pg_q, rdy_q;
    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] rd_sh;
    logic [CNT_W-1:0]  bitcnt;

    logic [HDR_W-1:0]  f_hdr;
    logic              f_data, f_read, f_prog, f_legal;
    logic              run, rise, fall, expired;

    mw_frame_fmt #(.ADDR_W(ADDR_W)) u_fmt (
        .cmd_i       (cmd_i),
        .addr_i      (addr_i),
        .hdr_o       (f_hdr),
        .with_data_o (f_data),
        .is_read_o   (f_read),
        .is_prog_o   (f_prog),
        .legal_o     (f_legal)
    );

    assign run = (state == ST_SEND) || (state == ST_RECV) ||
                 (state == ST_GAP)  || (state == ST_POLL);

    mw_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .sk_o   (sk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    mw_poll_timer #(.LIMIT(TIMEOUT_PERIODS)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (state != ST_POLL),
        .inc_i     (rise && (state == ST_POLL)),
        .expired_o (expired)
    );

    assign busy_o = (state != ST_IDLE);
    assign di_o   = sh[SH_W-1];

    // Command sequencer: load, send, receive, gap, poll, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cmd_q   <= '0;
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            pg_q    <= 1'b0;
            rdy_q   <= 1'b0;
            sh      <= '0;
            rd_sh   <= '0;
            bitcnt  <= '0;
            cs_o    <= 1'b0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i && f_legal) begin
                        cmd_q  <= cmd_i;
                        wr_q   <= f_data;
                        rd_q   <= f_read;
                        pg_q   <= f_prog;
                        sh     <= {f_hdr, (f_data ? wdata_i : {DATA_W{1'b0}})};
                        bitcnt <= '0;
                        cs_o   <= 1'b1;
                        err_o  <= 1'b0;
                        state  <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (rise)
                        bitcnt <= bitcnt + 1'b1;
                    if (fall) begin
                        if (bitcnt == (wr_q ? FULL_BITS : HDR_BITS)) begin
                            sh     <= '0;
                            bitcnt <= '0;
                            if (rd_q) begin
                                state <= ST_RECV;
                            end else begin
                                cs_o  <= 1'b0;
                                state <= pg_q ? ST_GAP : ST_END;
                            end
                        end else begin
                            sh <= sh << 1;
                        end
                    end
                end
                ST_RECV: begin
                    if (rise) begin
                        if (bitcnt != '0)
                            rd_sh <= {rd_sh[DATA_W-2:0], do_i};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (fall && (bitcnt == RD_BITS)) begin
                        rdata_o <= rd_sh;
                        cs_o    <= 1'b0;
                        state   <= ST_END;
                    end
                end
                ST_GAP: begin
                    if (fall) begin
                        cs_o  <= 1'b1;
                        rdy_q <= 1'b0;
                        state <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (rise)
                        rdy_q <= do_i;
                    if (fall) begin
                        if (rdy_q) begin
                            cs_o  <= 1'b0;
                            state <= ST_END;
                        end else if (expired) begin
                            cs_o  <= 1'b0;
                            err_o <= 1'b1;
                            state <= ST_END;
                        end
                    end
                end
                default: begin
                    done_o <= 1'b1;
                    state  <= ST_IDLE;
                end
            endcase
        end
    end

    // R1
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cs_o);
    // R3
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o && sk_o && $past(sk_o)) |-> $stable(di_o));
    // R11
    cs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_o) || $fell(cs_o)) |-> !sk_o);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R9
    hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(cmd_q));
endmodule

// File: tb/mw_eeprom_ctrl_test.sv
module mw_eeprom_ctrl_test;
    localparam int HALF    = 4;
    localparam int TMO     = 40;
    localparam int BUSY_CK = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cmd = '0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, err, cs, sk, di;
    logic [15:0] rdata;
    logic        dev_do = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = !clk;

    mw_eeprom_ctrl #(.HALF_DIV(HALF), .TIMEOUT_PERIODS(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd),
        .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done),
        .err_o(err), .rdata_o(rdata), .cs_o(cs), .sk_o(sk), .di_o(di),
        .do_i(dev_do)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural device model ----------------
    logic [15:0] mem [64];
    logic        wen = 1'b0, stuck = 1'b0, sk_q = 1'b0;
    logic        started = 1'b0, rd_mode = 1'b0, rd_bit = 1'b0;
    logic [7:0]  hdr8 = '0, last_hdr = '0;
    logic [15:0] dword = '0, rd_word = '0, pd = '0;
    logic [5:0]  pa = '0;
    int dbit = 0, pend = 0, busy_cnt = 0, frames = 0;

    initial for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;

    always @(posedge clk) begin
        sk_q <= sk;
        if (busy_cnt > 0 && !stuck) busy_cnt = busy_cnt - 1;
        if (!cs) begin
            started = 1'b0; dbit = 0; rd_mode = 1'b0;
            if (pend != 0) begin
                if (wen) begin
                    case (pend)
                        1: mem[pa] = pd;
                        2: mem[pa] = 16'hFFFF;
                        3: for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                        default: for (int i = 0; i < 64; i++) mem[i] = pd;
                    endcase
                    busy_cnt = BUSY_CK;
                end
                pend = 0;
            end
        end else if (sk && !sk_q) begin
            if (rd_mode) begin
                rd_bit = rd_word[15]; rd_word = rd_word << 1;
            end else if (!started) begin
                if (di) begin started = 1'b1; dbit = 0; end
            end else if (dbit < 8) begin
                hdr8 = {hdr8[6:0], di}; dbit++;
                if (dbit == 8) begin
                    frames++; last_hdr = hdr8; pa = hdr8[5:0];
                    case (hdr8[7:6])
                        2'b10: begin rd_mode = 1'b1; rd_bit = 1'b0; rd_word = mem[pa]; end
                        2'b11: begin pend = 2; dbit = 99; end
                        2'b01: ;
                        default: case (hdr8[5:4])
                            2'b11: begin wen = 1'b1; dbit = 99; end
                            2'b00: begin wen = 1'b0; dbit = 99; end
                            2'b10: begin pend = 3; dbit = 99; end
                            default: ;
                        endcase
                    endcase
                end
            end else if (dbit < 24) begin
                dword = {dword[14:0], di}; dbit++;
                if (dbit == 24) begin pd = dword; pend = (hdr8[7:6] == 2'b01) ? 1 : 4; end
            end
        end
        dev_do <= !cs ? 1'b0 : (rd_mode ? rd_bit : (busy_cnt == 0));
    end

    // ---------------- per-clock monitor ----------------
    logic sk_p = 1'b0, cs_p = 1'b0, di_p = 1'b0, done_p = 1'b0, last_valid = 1'b0;
    int hcnt = 0, cs_rises = 0, cur_gap = 0, max_gap = 0;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
        if (rst_n) begin
            if (sk != sk_p) begin
                // R3 half period length
                if (cs && last_valid) check(hcnt + 1 == HALF, "R3 half period", hcnt + 1, HALF);
                last_valid = cs; hcnt = 0;
            end else hcnt++;
            // R3 data stable while clock high
            if (cs && sk && sk_p) check(di == di_p, "R3 di stable", di, di_p);
            // R11 chip select moves with clock low
            if (cs != cs_p) check(!sk, "R11 cs edge", sk, 0);
            // R10 done pulse
            if (done) check(!done_p && !busy, "R10 done pulse", {done_p, busy}, 0);
            // R1 idle implies deselected
            if (!busy) check(!cs, "R1 idle cs", cs, 0);
            if (cs && !cs_p) cs_rises++;
            if (busy && !cs) cur_gap++;
            else begin
                if (cur_gap > max_gap) max_gap = cur_gap;
                cur_gap = 0;
            end
        end
        sk_p = sk; cs_p = cs; di_p = di; done_p = done;
    end

    // ---------------- command driver ----------------
    logic [15:0] r_data;
    logic        r_err;
    int          r_rises, r_cycles, r_gap;

    task automatic run_cmd(input logic [2:0] c, input logic [5:0] a, input logic [15:0] w);
        int r0, t0;
        @(negedge clk);
        cmd = c; addr = a; wdata = w; start = 1'b1;
        r0 = cs_rises; t0 = cyc; max_gap = 0;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        r_data = rdata; r_err = err; r_rises = cs_rises - r0;
        r_cycles = cyc - t0; r_gap = max_gap;
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_hdr(input logic [2:0] c, input logic [5:0] a);
        case (c)
            3'd0: return {2'b10, a};
            3'd1: return {2'b01, a};
            3'd2: return {2'b11, a};
            3'd3: return 8'b00_10_0000;
            3'd4: return 8'b00_01_0000;
            3'd5: return 8'b00_11_0000;
            default: return 8'b00_00_0000;
        endcase
    endfunction

    task automatic do_read(input logic [5:0] a, input logic [15:0] exp, input string req);
        run_cmd(3'd0, a, 16'h0);
        check(last_hdr == exp_hdr(3'd0, a), "R2 read frame", last_hdr, exp_hdr(3'd0, a));
        check(r_data == exp, req, r_data, exp);
        check(r_err == 1'b0 && r_rises == 1, "R10 read err/cs", {r_err, 8'(r_rises)}, 1);
    endtask

    task automatic do_prog(input logic [2:0] c, input logic [5:0] a, input logic [15:0] w,
                           input bit enabled);
        run_cmd(c, a, w);
        check(last_hdr == exp_hdr(c, a), "R2 frame header", last_hdr, exp_hdr(c, a));
        check(r_rises == 2, "R6 reselect for poll", r_rises, 2);
        check(r_gap >= 2 * HALF, "R6 cs low gap", r_gap, 2 * HALF);
        check(r_err == 1'b0, "R10 err low", r_err, 0);
        if (enabled) check(r_cycles > BUSY_CK, "R6 waits for ready", r_cycles, BUSY_CK);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check({cs, sk, di, busy, done} == 5'b0, "R1 reset outputs", {cs, sk, di, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_read(6'd5, 16'hFFFF, "R4 erased word");
        // writes are gated until enabled
        do_prog(3'd1, 6'd5, 16'h1234, 1'b0);
        do_read(6'd5, 16'hFFFF, "R4 gated write");

        // R8 enable: frame only
        run_cmd(3'd5, 6'h2A, 16'h0);
        check(last_hdr == exp_hdr(3'd5, 6'h2A), "R8 enable frame", last_hdr, exp_hdr(3'd5, 6'h2A));
        check(r_rises == 1 && r_err == 1'b0, "R8 no poll", r_rises, 1);

        do_prog(3'd1, 6'd5, 16'hA5C3, 1'b1);
        do_read(6'd5, 16'hA5C3, "R5 write data");
        do_prog(3'd1, 6'd63, 16'h8001, 1'b1);
        do_read(6'd63, 16'h8001, "R5 top address");
        do_prog(3'd2, 6'd5, 16'h0, 1'b1);
        do_read(6'd5, 16'hFFFF, "R6 erase");
        do_read(6'd63, 16'h8001, "R4 erase neighbour");
        do_prog(3'd4, 6'd9, 16'h0F0F, 1'b1);
        do_read(6'd0, 16'h0F0F, "R5 write-all low");
        do_read(6'd63, 16'h0F0F, "R5 write-all high");
        do_prog(3'd3, 6'd3, 16'h0, 1'b1);
        do_read(6'd17, 16'hFFFF, "R6 erase-all");

        // R9 strobe while busy ignored
        begin
            int f0;
            do_prog(3'd1, 6'd1, 16'h5A5A, 1'b1);
            f0 = frames;
            @(negedge clk);
            cmd = 3'd0; addr = 6'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (6) @(negedge clk);
            cmd = 3'd1; addr = 6'd2; wdata = 16'h0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (!done) @(negedge clk);
            check(rdata == 16'h5A5A, "R9 busy strobe read", rdata, 16'h5A5A);
            repeat (40) @(negedge clk);
            check(frames == f0 + 1 && !busy, "R9 busy strobe ignored", frames - f0, 1);
            do_read(6'd2, 16'hFFFF, "R9 ignored write");
        end

        // R9 reserved code
        begin
            int f0;
            f0 = frames;
            @(negedge clk);
            cmd = 3'd7; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            check(!busy && !cs && frames == f0, "R9 code 7", {busy, cs}, 0);
        end

        // R7 timeout
        stuck = 1'b1;
        run_cmd(3'd2, 6'd7, 16'h0);
        check(r_err == 1'b1, "R7 timeout err", r_err, 1);
        check(r_cycles >= TMO * 2 * HALF, "R7 timeout length", r_cycles, TMO * 2 * HALF);
        stuck = 1'b0;
        repeat (BUSY_CK + 20) @(negedge clk);

        // R8 disable, then writes gated again
        run_cmd(3'd6, 6'd0, 16'h0);
        check(last_hdr == exp_hdr(3'd6, 6'd0) && r_rises == 1, "R8 disable frame", last_hdr, exp_hdr(3'd6, 6'd0));
        do_prog(3'd1, 6'd2, 16'h1111, 1'b0);
        do_read(6'd2, 16'hFFFF, "R8 disabled write");
        do_prog(3'd0 + 3'd1, 6'd3, 16'h2222, 1'b0);
        check(r_err == 1'b0, "R10 err cleared after timeout", r_err, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule